// File: doc/BRIEF.md
# Paged Address Translator with Access Checking

This block maps the lower 4 MiB of a 24-bit CPU address space onto physical memory through a table of 1024 page entries. Each entry is 16 bits wide and covers a 4 KiB page. For every address presented it returns a physical address and a three-bit permission verdict in the same cycle. When a strobed access is permitted on a page that is present, the block records it in the entry: a read marks the page as accessed, and a write marks it as accessed and modified.

Supervisor accesses are always granted. User accesses go through a fixed chain of checks. An address outside the translated window is refused first. A missing page is refused next, then a page in the low kernel region, then a write to a page that is not writable. A host port lets system software read any entry and write it. When a host write and a status update hit the same entry in the same cycle, the host value is the one kept.

Top module: `page_mmu`

## Requirements
- R1: Addresses at or above 0x400000 (bits [23:22] not both zero) are returned unchanged on `phys_addr_o`.
- R2: For addresses below 0x400000 the page index is bits [21:12]. `phys_addr_o` is two zero bits, then entry bits [9:0], then address bits [11:0].
- R3: With `acc_super_i` high, `status_o` is 0 (allowed) for every address.
- R4: A user access at or above 0x400000 gives status 4 (non-memory access), ahead of every other check.
- R5: A user access to a page whose entry bits [14:13] are both zero gives status 1 (page fault), ahead of the kernel check.
- R6: A user access to a present page with address bits [22:19] all zero gives status 3 (kernel region), ahead of the write-enable check.
- R7: A user write to a present, non-kernel page whose entry bit 15 is clear gives status 2 (not writable). A read of such a page gives status 0.
- R8: A strobed access (`acc_valid_i` high) with status 0 to a present page below 0x400000 updates the entry on the next clock edge. A read sets bit 14 and a write sets bits 14 and 13. All other bits keep their value.
- R9: The entry is left unchanged when the page is not present, when the status is not 0, or when `acc_valid_i` is low.
- R10: A host write lands on the next clock edge. If it targets the entry that a status update targets in the same cycle, the host data is kept. If it targets a different entry, both writes land.
- R11: Reset clears every entry to zero. `host_rdata_o` shows the entry selected by `host_idx_i` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe; allows the status-bit update |
| acc_addr_i | input | 24 | Virtual address of the access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_super_i | input | 1 | 1 = supervisor mode |
| phys_addr_o | output | 24 | Translated or passed-through address |
| status_o | output | 3 | 0 ok, 1 page fault, 2 not writable, 3 kernel, 4 non-memory |
| host_we_i | input | 1 | Host write strobe for a map entry |
| host_idx_i | input | 10 | Map entry index for the host port |
| host_wdata_i | input | 16 | Entry value to write |
| host_rdata_o | output | 16 | Entry value at `host_idx_i` |

## Verification
Two functions can act in the same cycle: a host write to an entry, and the accessed/modified update caused by a permitted access. The bench provokes the collision by strobing a permitted write access and a host write to the same page index on one clock edge. It then reads the entry back and expects exactly the host data, with no status bits ORed in. A second cycle aims the two writes at different entries, and both results must appear.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int ADDR_W  = 24;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ENT_W   = 16;
  localparam int PPN_W   = 10;
  localparam int ST_LO   = 13;  // present/accessed field low bit
  localparam int ST_HI   = 14;  // accessed bit
  localparam int WE_BIT  = 15;
  localparam int KERN_LO = 19;
  localparam int KERN_HI = 22;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_PFAULT = 3'd1,
    ST_NOWR   = 3'd2,
    ST_KERN   = 3'd3,
    ST_NONMEM = 3'd4
  } mmu_status_e;
endpackage

// File: rtl/mmu_map_ram.sv
module mmu_map_ram
  import mmu_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int EW = ENT_W,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [IW-1:0] host_idx_i,
  input  logic [EW-1:0] host_wdata_i,
  output logic [EW-1:0] host_rdata_o,
  input  logic [IW-1:0] lk_idx_i,
  output logic [EW-1:0] lk_entry_o,
  input  logic          upd_en_i,
  input  logic [EW-1:0] upd_entry_i
);
  logic [EW-1:0] mem_q [DEPTH];

  assign host_rdata_o = mem_q[host_idx_i];
  assign lk_entry_o   = mem_q[lk_idx_i];

  // later assignment wins: host write overrides the status update on the same index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (upd_en_i)  mem_q[lk_idx_i]   <= upd_entry_i;
      if (host_we_i) mem_q[host_idx_i] <= host_wdata_i;
    end
  end
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_pkg::*;
(
  input  logic        in_range_i,
  input  logic        present_i,
  input  logic        kernel_i,
  input  logic        wr_en_i,
  input  logic        write_i,
  input  logic        super_i,
  output mmu_status_e status_o
);
  always_comb begin
    if (super_i)                status_o = ST_OK;
    else if (!in_range_i)       status_o = ST_NONMEM;
    else if (!present_i)        status_o = ST_PFAULT;
    else if (kernel_i)          status_o = ST_KERN;
    else if (write_i && !wr_en_i) status_o = ST_NOWR;
    else                        status_o = ST_OK;
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int IW = IDX_W,
  parameter int PW = PPN_W,
  parameter int EW = ENT_W,
  localparam int PAD_W = AW - PW - OW
) (
  input  logic [AW-1:0] addr_i,
  input  logic [EW-1:0] entry_i,
  output logic          in_range_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] phys_o
);
  assign in_range_o = (addr_i[AW-1:IW+OW] == '0);
  assign idx_o      = addr_i[IW+OW-1:OW];

  generate
    if (PAD_W > 0) begin : g_pad
      assign phys_o = in_range_o ? {{PAD_W{1'b0}}, entry_i[PW-1:0], addr_i[OW-1:0]} : addr_i;
    end else begin : g_nopad
      assign phys_o = in_range_o ? {entry_i[PW-1:0], addr_i[OW-1:0]} : addr_i;
    end
  endgenerate
endmodule

// File: rtl/page_mmu.sv
module page_mmu
  import mmu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W,
  parameter int EW = ENT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_write_i,
  input  logic          acc_super_i,
  output logic [AW-1:0] phys_addr_o,
  output logic [2:0]    status_o,
  input  logic          host_we_i,
  input  logic [IW-1:0] host_idx_i,
  input  logic [EW-1:0] host_wdata_i,
  output logic [EW-1:0] host_rdata_o
);
  logic [IW-1:0] lk_idx;
  logic [EW-1:0] lk_entry, upd_entry;
  logic          in_range, present, kernel, upd_en;
  mmu_status_e   status;

  mmu_xlate #(.AW(AW), .IW(IW), .EW(EW)) u_xlate (
    .addr_i     (acc_addr_i),
    .entry_i    (lk_entry),
    .in_range_o (in_range),
    .idx_o      (lk_idx),
    .phys_o     (phys_addr_o)
  );

  assign present = |lk_entry[ST_HI:ST_LO];
  assign kernel  = (acc_addr_i[KERN_HI:KERN_LO] == '0);

  mmu_access_check u_chk (
    .in_range_i (in_range),
    .present_i  (present),
    .kernel_i   (kernel),
    .wr_en_i    (lk_entry[WE_BIT]),
    .write_i    (acc_write_i),
    .super_i    (acc_super_i),
    .status_o   (status)
  );

  assign status_o = status;

  assign upd_en = acc_valid_i && in_range && present && (status == ST_OK);

  always_comb begin
    upd_entry        = lk_entry;
    upd_entry[ST_HI] = 1'b1;
    if (acc_write_i) upd_entry[ST_LO] = 1'b1;
  end

  mmu_map_ram #(.IW(IW), .EW(EW)) u_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_idx_i   (host_idx_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .lk_idx_i     (lk_idx),
    .lk_entry_o   (lk_entry),
    .upd_en_i     (upd_en),
    .upd_entry_i  (upd_entry)
  );
endmodule

// File: rtl/page_mmu_chk.sv
module page_mmu_chk
  import mmu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W,
  parameter int EW = ENT_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic          acc_write_i,
  input logic          acc_super_i,
  input logic [AW-1:0] phys_addr_o,
  input logic [2:0]    status_o,
  input logic          host_we_i,
  input logic [IW-1:0] host_idx_i,
  input logic [EW-1:0] host_wdata_i,
  input logic [EW-1:0] host_rdata_o
);
  logic out_rng;
  assign out_rng = (acc_addr_i[AW-1:IW+OFF_W] != '0);

  assert_passthru_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rng |-> phys_addr_o == acc_addr_i);

  assert_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_rng |-> (phys_addr_o[OFF_W-1:0] == acc_addr_i[OFF_W-1:0]) &&
                 (phys_addr_o[AW-1:PPN_W+OFF_W] == '0));

  assert_super_ok_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_super_i |-> status_o == ST_OK);

  assert_nonmem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_super_i && out_rng) |-> status_o == ST_NONMEM);

  assert_fault_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_PFAULT) |-> (!acc_super_i && !out_rng));

  assert_kernel_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_KERN) |-> (acc_addr_i[KERN_HI:KERN_LO] == '0));

  assert_nowr_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_NOWR) |-> acc_write_i);

  assert_host_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i |=> (host_idx_i != $past(host_idx_i)) || (host_rdata_o == $past(host_wdata_i)));
endmodule

bind page_mmu page_mmu_chk #(.AW(AW), .IW(IW), .EW(EW)) u_page_mmu_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_addr_i   (acc_addr_i),
  .acc_write_i  (acc_write_i),
  .acc_super_i  (acc_super_i),
  .phys_addr_o  (phys_addr_o),
  .status_o     (status_o),
  .host_we_i    (host_we_i),
  .host_idx_i   (host_idx_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o)
);

// File: tb/tb_page_mmu.sv
module tb_page_mmu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_super = 1'b0;
  logic [23:0] phys_addr;
  logic [2:0]  status;
  logic        host_we = 1'b0;
  logic [9:0]  host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  page_mmu dut (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_write_i(acc_write), .acc_super_i(acc_super),
    .phys_addr_o(phys_addr), .status_o(status),
    .host_we_i(host_we), .host_idx_i(host_idx),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata)
  );

  typedef struct packed {
    logic [23:0] addr;
    logic        wr;
    logic        sup;
    logic [23:0] phys;
    logic [2:0]  st;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{24'h080123, 1'b0, 1'b0, 24'h155123, 3'd0},  // R2 translate read
    '{24'h080FFF, 1'b1, 1'b0, 24'h155FFF, 3'd0},  // R2 writable page write
    '{24'h081456, 1'b0, 1'b0, 24'h0AA456, 3'd0},  // R7 read of non-writable page
    '{24'h081456, 1'b1, 1'b0, 24'h0AA456, 3'd2},  // R7 write refused
    '{24'h082000, 1'b0, 1'b0, 24'h033000, 3'd1},  // R5 page not present
    '{24'h005ABC, 1'b0, 1'b0, 24'h011ABC, 3'd3},  // R6 kernel region
    '{24'h006001, 1'b1, 1'b0, 24'h022001, 3'd3},  // R6 kernel ahead of write-enable
    '{24'h005ABC, 1'b1, 1'b1, 24'h011ABC, 3'd0},  // R3 supervisor
    '{24'h082000, 1'b1, 1'b1, 24'h033000, 3'd0},  // R3 supervisor on absent page
    '{24'h400010, 1'b0, 1'b0, 24'h400010, 3'd4},  // R4 and R1
    '{24'h9ABCDE, 1'b1, 1'b1, 24'h9ABCDE, 3'd0},  // R1 passthrough supervisor
    '{24'h3FF000, 1'b0, 1'b0, 24'h000000, 3'd1},  // R5 top page cleared
    '{24'h002000, 1'b0, 1'b0, 24'h000000, 3'd1}   // R5 absent precedes kernel
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [9:0] idx, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = idx; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_check(input string req, input logic [9:0] idx, input logic [15:0] exp);
    @(negedge clk);
    host_idx = idx;
    #1 check(req, {16'h0, host_rdata}, {16'h0, exp});
  endtask

  task automatic strobe(input logic [23:0] a, input logic w, input logic s);
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_super = s; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    host_check("R11 reset entry 0", 10'h000, 16'h0000);
    host_check("R11 reset entry 0x3FF", 10'h3FF, 16'h0000);

    host_write(10'h080, 16'hA155);
    host_write(10'h081, 16'h20AA);
    host_write(10'h082, 16'h8033);
    host_write(10'h005, 16'hA011);
    host_write(10'h006, 16'h2022);
    host_write(10'h083, 16'hC077);
    host_check("R11 host readback", 10'h082, 16'h8033);

    // table walk, strobe low: combinational outputs only
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_addr = VEC[i].addr; acc_write = VEC[i].wr; acc_super = VEC[i].sup;
      #1;
      check($sformatf("R1/R2 phys vec %0d", i), {8'h0, phys_addr}, {8'h0, VEC[i].phys});
      check($sformatf("R3-R7 status vec %0d", i), {29'h0, status}, {29'h0, VEC[i].st});
    end
    host_check("R9 no update with strobe low", 10'h080, 16'hA155);

    // R8 read sets accessed only
    strobe(24'h083010, 1'b0, 1'b0);
    host_check("R8 read keeps bit13", 10'h083, 16'hC077);
    strobe(24'h083010, 1'b1, 1'b0);
    host_check("R8 write sets bit13", 10'h083, 16'hE077);
    // R9 refused write leaves entry, then permitted read sets bit 14
    strobe(24'h081000, 1'b1, 1'b0);
    host_check("R9 refused write no update", 10'h081, 16'h20AA);
    strobe(24'h081000, 1'b0, 1'b0);
    host_check("R8 read sets bit14", 10'h081, 16'h60AA);
    // R9 absent page with supervisor
    strobe(24'h082000, 1'b1, 1'b1);
    host_check("R9 absent page no update", 10'h082, 16'h8033);
    // R9 kernel denial
    strobe(24'h005000, 1'b0, 1'b0);
    host_check("R9 kernel denial no update", 10'h005, 16'hA011);
    // R8 supervisor write on kernel page
    strobe(24'h005000, 1'b1, 1'b1);
    host_check("R8 supervisor write update", 10'h005, 16'hE011);

    // R10 collision on same entry: host wins
    @(negedge clk);
    acc_addr = 24'h080000; acc_write = 1'b1; acc_super = 1'b0; acc_valid = 1'b1;
    host_we = 1'b1; host_idx = 10'h080; host_wdata = 16'h8123;
    @(negedge clk);
    acc_valid = 1'b0; host_we = 1'b0;
    host_check("R10 same entry host wins", 10'h080, 16'h8123);

    // R10 different entries: both land
    @(negedge clk);
    acc_addr = 24'h006000; acc_write = 1'b0; acc_super = 1'b1; acc_valid = 1'b1;
    host_we = 1'b1; host_idx = 10'h084; host_wdata = 16'h5555;
    @(negedge clk);
    acc_valid = 1'b0; host_we = 1'b0;
    host_check("R10 host side lands", 10'h084, 16'h5555);
    host_check("R10 update side lands", 10'h006, 16'h6022);

    // R11 reset clears programmed entries
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    host_check("R11 reset clears entry", 10'h083, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule